// File: doc/BRIEF.md
# Address-Space-Tagged Translation Buffer with Entry Locking

This block is a small fully associative translation cache. Each slot holds a virtual page, a physical page, an address-space tag, a global flag, a valid bit and a lock bit. A lookup port returns a hit and the physical page in the same cycle it is asked. A match needs a valid slot with the same virtual page, and the slot must either be global or carry the current address-space tag.

New translations come in on a valid/ready fill stream. A maintenance command port takes an opcode plus a page and a tag. Commands have priority: while a command is presented, `fill_ready` is low and the fill must be held until it is accepted. Fills never stall otherwise. A separate lock port marks the slots that match a page and tag as locked. Locked slots survive a full flush and are never picked as a replacement victim. When every slot is valid and locked, an accepted fill is discarded and `fill_err` pulses for one cycle.

Top module: `asid_tlb`

## Requirements
- R1: While reset is low and after it, every slot is invalid and unlocked: lookups miss and `fill_err` is low.
- R2: `lk_hit` is high in the same cycle when some valid slot has `lk_vpn` and is either global or tagged `lk_asid`; `lk_ppn` then gives that slot's physical page (lowest index if several). On a miss, `lk_ppn` is zero.
- R3: An accepted fill goes to the lowest-index invalid slot. If there is none, it goes to the first unlocked slot at or after a round-robin pointer. The pointer starts at 0 and moves to the slot after each such victim, wrapping from the last slot to 0. A filled slot is unlocked.
- R4: When an accepted fill finds all slots valid and locked, no slot changes and `fill_err` is high for exactly the following cycle.
- R5: `fill_ready` is low in any cycle with `cmd_valid` high and high otherwise. A fill is taken only when both `fill_valid` and `fill_ready` are high.
- R6: Opcode 0 (flush) invalidates every valid slot that is not locked.
- R7: Opcode 1 (page and tag) invalidates slots whose page equals `cmd_vpn` and that are global or tagged `cmd_asid`.
- R8: Opcode 2 (tag) invalidates non-global slots tagged `cmd_asid`; global slots stay.
- R9: Opcode 3 (page, any tag) invalidates every slot whose page equals `cmd_vpn`, locked or not.
- R10: Opcode 4 (unlock all) clears every lock bit and leaves valid bits unchanged.
- R11: `lock_valid` locks each valid slot that a lookup of `lock_vpn`/`lock_asid` would hit. A slot that is invalidated loses its lock.
- R12: Every command and lock takes effect at the next clock edge; a lookup in the same cycle sees the earlier state. Opcodes 5 to 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_vpn | input | VPN_W | Lookup virtual page |
| lk_asid | input | ASID_W | Current address-space tag |
| lk_hit | output | 1 | Lookup hit |
| lk_ppn | output | PPN_W | Physical page on hit |
| fill_valid | input | 1 | Fill presented |
| fill_ready | output | 1 | Fill accepted this cycle |
| fill_vpn | input | VPN_W | Fill virtual page |
| fill_ppn | input | PPN_W | Fill physical page |
| fill_asid | input | ASID_W | Fill tag |
| fill_global | input | 1 | Fill is global |
| fill_err | output | 1 | Fill dropped, all slots locked |
| cmd_valid | input | 1 | Maintenance command presented |
| cmd_op | input | 3 | Maintenance opcode |
| cmd_vpn | input | VPN_W | Command page operand |
| cmd_asid | input | ASID_W | Command tag operand |
| lock_valid | input | 1 | Lock request |
| lock_vpn | input | VPN_W | Page to lock |
| lock_asid | input | ASID_W | Tag used for lock match |

## Verification
The hardest state to reach is a buffer that is full with every slot locked. Only then does a fill get dropped and raise the error pulse. The stimulus first fills all eight slots with distinct pages, then sends one lock request per page with the matching tag, and then offers one more fill. Earlier phases lock only some slots and flush, so the round-robin pointer is checked for skipping locked slots before the all-locked case is tried. A fill that collides with a command is held through a back-pressured cycle.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef enum logic [2:0] {
    OP_FLUSH       = 3'd0,
    OP_PAGE_TAG    = 3'd1,
    OP_TAG         = 3'd2,
    OP_PAGE_ANY    = 3'd3,
    OP_UNLOCK_ALL  = 3'd4
  } tlb_op_e;
endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int N      = 8,
  parameter int VPN_W  = 20,
  parameter int ASID_W = 8
) (
  input  logic [N-1:0][VPN_W-1:0]  e_vpn,
  input  logic [N-1:0][ASID_W-1:0] e_asid,
  input  logic [VPN_W-1:0]         q_vpn,
  input  logic [ASID_W-1:0]        q_asid,
  output logic [N-1:0]             page_eq,
  output logic [N-1:0]             tag_eq
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign page_eq[g] = (e_vpn[g] == q_vpn);
    assign tag_eq[g]  = (e_asid[g] == q_asid);
  end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int N  = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  valid,
  input  logic [N-1:0]  lock,
  input  logic [IW-1:0] rr_ptr,
  output logic [IW-1:0] idx,
  output logic          found,
  output logic          by_rr
);
  logic [IW-1:0] free_idx, rr_idx;
  logic          free_any, rr_ok;

  always_comb begin
    free_idx = '0;
    free_any = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!valid[i]) begin
        free_any = 1'b1;
        free_idx = IW'(i);
      end
    end
  end

  always_comb begin
    rr_idx = '0;
    rr_ok  = 1'b0;
    for (int k = N - 1; k >= 0; k--) begin
      int j;
      j = int'(rr_ptr) + k;
      if (j >= N) j = j - N;
      if (!lock[j]) begin
        rr_ok  = 1'b1;
        rr_idx = IW'(j);
      end
    end
  end

  assign found = free_any | rr_ok;
  assign by_rr = !free_any & rr_ok;
  assign idx   = free_any ? free_idx : rr_idx;
endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
  import tlb_pkg::*;
#(
  parameter int N      = 8,
  parameter int VPN_W  = 20,
  parameter int PPN_W  = 20,
  parameter int ASID_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [ASID_W-1:0] lk_asid,
  output logic              lk_hit,
  output logic [PPN_W-1:0]  lk_ppn,
  input  logic              fill_valid,
  output logic              fill_ready,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [PPN_W-1:0]  fill_ppn,
  input  logic [ASID_W-1:0] fill_asid,
  input  logic              fill_global,
  output logic              fill_err,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [VPN_W-1:0]  cmd_vpn,
  input  logic [ASID_W-1:0] cmd_asid,
  input  logic              lock_valid,
  input  logic [VPN_W-1:0]  lock_vpn,
  input  logic [ASID_W-1:0] lock_asid
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0][VPN_W-1:0]  e_vpn;
  logic [N-1:0][PPN_W-1:0]  e_ppn;
  logic [N-1:0][ASID_W-1:0] e_asid;
  logic [N-1:0]             e_valid, e_glob, e_lock;
  logic [IW-1:0]            rr_ptr;

  logic [N-1:0] lk_page, lk_tag, lk_sel;
  logic [N-1:0] lo_page, lo_tag, lo_sel;
  logic [N-1:0] cm_page, cm_tag;

  tlb_match #(.N(N), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_lk_match (
    .e_vpn(e_vpn), .e_asid(e_asid), .q_vpn(lk_vpn), .q_asid(lk_asid),
    .page_eq(lk_page), .tag_eq(lk_tag));
  tlb_match #(.N(N), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_lo_match (
    .e_vpn(e_vpn), .e_asid(e_asid), .q_vpn(lock_vpn), .q_asid(lock_asid),
    .page_eq(lo_page), .tag_eq(lo_tag));
  tlb_match #(.N(N), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_cm_match (
    .e_vpn(e_vpn), .e_asid(e_asid), .q_vpn(cmd_vpn), .q_asid(cmd_asid),
    .page_eq(cm_page), .tag_eq(cm_tag));

  assign lk_sel = e_valid & lk_page & (e_glob | lk_tag);
  assign lo_sel = e_valid & lo_page & (e_glob | lo_tag);

  // lookup output: lowest matching slot
  always_comb begin
    lk_ppn = '0;
    for (int i = N - 1; i >= 0; i--)
      if (lk_sel[i]) lk_ppn = e_ppn[i];
  end
  assign lk_hit = |lk_sel;

  // victim choice
  logic [IW-1:0] v_idx;
  logic          v_found, v_by_rr;
  tlb_victim #(.N(N)) u_victim (
    .valid(e_valid), .lock(e_lock), .rr_ptr(rr_ptr),
    .idx(v_idx), .found(v_found), .by_rr(v_by_rr));

  assign fill_ready = !cmd_valid;
  logic fill_go;
  assign fill_go = fill_valid & fill_ready;

  // maintenance decode
  logic [N-1:0] kill;
  logic         unlock_all;
  always_comb begin
    kill       = '0;
    unlock_all = 1'b0;
    if (cmd_valid) begin
      case (cmd_op)
        OP_FLUSH:      kill = e_valid & ~e_lock;
        OP_PAGE_TAG:   kill = cm_page & (e_glob | cm_tag);
        OP_TAG:        kill = cm_tag & ~e_glob;
        OP_PAGE_ANY:   kill = cm_page;
        OP_UNLOCK_ALL: unlock_all = 1'b1;
        default:       kill = '0;
      endcase
    end
  end

  logic [N-1:0] nxt_valid, nxt_lock;
  always_comb begin
    nxt_valid = e_valid & ~kill;
    nxt_lock  = ((e_lock & ~{N{unlock_all}}) | (lock_valid ? lo_sel : '0)) & nxt_valid;
    if (fill_go && v_found) begin
      nxt_valid[v_idx] = 1'b1;
      nxt_lock[v_idx]  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_valid  <= '0;
      e_lock   <= '0;
      rr_ptr   <= '0;
      fill_err <= 1'b0;
    end else begin
      e_valid  <= nxt_valid;
      e_lock   <= nxt_lock;
      fill_err <= fill_go && !v_found;
      if (fill_go && v_by_rr)
        rr_ptr <= (int'(v_idx) == N - 1) ? '0 : v_idx + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_go && v_found) begin
      e_vpn[v_idx]  <= fill_vpn;
      e_ppn[v_idx]  <= fill_ppn;
      e_asid[v_idx] <= fill_asid;
      e_glob[v_idx] <= fill_global;
    end
  end
endmodule

// File: rtl/tlb_chk.sv
module tlb_chk #(
  parameter int VPN_W  = 20,
  parameter int ASID_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              fill_valid,
  input logic              fill_ready,
  input logic              fill_err,
  input logic              lock_valid,
  input logic [VPN_W-1:0]  lk_vpn,
  input logic [ASID_W-1:0] lk_asid,
  input logic              lk_hit
);
  // R5
  ready_backpressure_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !fill_ready);

  // R4
  err_needs_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_err |-> $past(fill_valid && fill_ready));

  // R4
  err_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_err |=> !fill_err || $past(fill_valid && fill_ready));

  // R1
  reset_no_err_chk: assert property (@(posedge clk)
    !rst_n |=> !fill_err);

  // R12
  quiet_hit_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(lk_vpn) && $stable(lk_asid) && !$past(cmd_valid)
     && !$past(fill_valid) && !$past(lock_valid)) |-> $stable(lk_hit));
endmodule

bind asid_tlb tlb_chk #(.VPN_W(VPN_W), .ASID_W(ASID_W)) u_chk (.*);

// File: tb/test_asid_tlb.sv
`timescale 1ns/1ps
module test_asid_tlb;
  localparam int N = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [19:0] lk_vpn = '0, fill_vpn = '0, fill_ppn = '0, cmd_vpn = '0, lock_vpn = '0;
  logic [7:0]  lk_asid = '0, fill_asid = '0, cmd_asid = '0, lock_asid = '0;
  logic [2:0]  cmd_op = '0;
  logic fill_valid = 0, fill_global = 0, cmd_valid = 0, lock_valid = 0;
  logic lk_hit, fill_ready, fill_err;
  logic [19:0] lk_ppn;

  asid_tlb i_asid_tlb (.*);

  int checks = 0, errors = 0;
  bit done = 0;
  string tag = "R1";

  bit mv[N], ml[N], mg[N];
  int mvpn[N], mppn[N], mas[N];
  int mrr = 0;
  bit exp_err = 0;

  task automatic chk(string t, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", t, act, exp);
    end
  endtask

  function automatic bit hits(int i, int v, int a);
    return mv[i] && mvpn[i] == v && (mg[i] || mas[i] == a);
  endfunction

  task automatic step();
    bit nv[N], nl[N];
    bit eh, go, drop;
    int ep, vi;
    #1;
    eh = 0; ep = 0;
    for (int i = N - 1; i >= 0; i--)
      if (hits(i, int'(lk_vpn), int'(lk_asid))) begin eh = 1; ep = mppn[i]; end
    chk({tag, " lookup hit (R2)"}, int'(lk_hit), int'(eh));
    chk({tag, " lookup ppn (R2)"}, int'(lk_ppn), ep);
    chk("R5 fill_ready", int'(fill_ready), int'(!cmd_valid));
    for (int i = 0; i < N; i++) begin
      nv[i] = mv[i]; nl[i] = ml[i];
      if (cmd_valid) begin
        case (cmd_op)
          3'd0: if (!ml[i]) nv[i] = 0;
          3'd1: if (mvpn[i] == int'(cmd_vpn) && (mg[i] || mas[i] == int'(cmd_asid))) nv[i] = 0;
          3'd2: if (!mg[i] && mas[i] == int'(cmd_asid)) nv[i] = 0;
          3'd3: if (mvpn[i] == int'(cmd_vpn)) nv[i] = 0;
          3'd4: nl[i] = 0;
          default: ;
        endcase
      end
      if (lock_valid && hits(i, int'(lock_vpn), int'(lock_asid))) nl[i] = 1;
      if (!nv[i]) nl[i] = 0;
    end
    go = fill_valid && !cmd_valid;
    drop = 0;
    if (go) begin
      vi = -1;
      for (int i = 0; i < N; i++) if (!mv[i] && vi < 0) vi = i;
      if (vi < 0) begin
        for (int k = 0; k < N; k++)
          if (vi < 0 && !ml[(mrr + k) % N]) vi = (mrr + k) % N;
        if (vi >= 0) mrr = (vi + 1) % N;
      end
      if (vi < 0) drop = 1;
      else begin
        nv[vi] = 1; nl[vi] = 0; mvpn[vi] = int'(fill_vpn); mppn[vi] = int'(fill_ppn);
        mas[vi] = int'(fill_asid); mg[vi] = fill_global;
      end
    end
    @(posedge clk);
    for (int i = 0; i < N; i++) begin mv[i] = nv[i]; ml[i] = nl[i]; end
    exp_err = drop;
    @(negedge clk);
    chk({tag, " fill_err (R4)"}, int'(fill_err), int'(exp_err));
  endtask

  task automatic fill(int v, int p, int a, bit g);
    fill_valid = 1; fill_vpn = 20'(v); fill_ppn = 20'(p); fill_asid = 8'(a); fill_global = g;
    step();
    fill_valid = 0;
  endtask

  task automatic cmd(int op, int v, int a);
    cmd_valid = 1; cmd_op = 3'(op); cmd_vpn = 20'(v); cmd_asid = 8'(a);
    step();
    cmd_valid = 0;
  endtask

  task automatic lock(int v, int a);
    lock_valid = 1; lock_vpn = 20'(v); lock_asid = 8'(a);
    step();
    lock_valid = 0;
  endtask

  task automatic look(int v, int a);
    lk_vpn = 20'(v); lk_asid = 8'(a);
    step();
  endtask

  task automatic probe(int base);
    for (int i = 0; i < N; i++)
      for (int a = 1; a <= 3; a++) look(base + i, a);
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin mv[i] = 0; ml[i] = 0; mg[i] = 0; end
    repeat (3) @(negedge clk);
    chk("R1 hit in reset", int'(lk_hit), 0);
    chk("R1 err in reset", int'(fill_err), 0);
    rst_n = 1;
    @(negedge clk);
    tag = "R1"; probe('h100);

    tag = "R3";
    for (int i = 0; i < N; i++) fill('h100 + i, 'h5000 + i, i % 3 + 1, i == 2);
    probe('h100);
    fill('h200, 'h6000, 1, 0);
    fill('h201, 'h6001, 1, 0);
    look('h100, 1); chk("R3 slot 0 replaced", int'(lk_hit), 0);
    look('h201, 1); chk("R3 new entry hit", int'(lk_ppn), 'h6001);
    look('h102, 7); chk("R2 global any tag", int'(lk_hit), 1);

    tag = "R11";
    lock('h102, 9);
    lock('h103, 1);
    fill('h202, 'h6002, 2, 0);
    fill('h203, 'h6003, 2, 0);
    look('h103, 1); chk("R11 locked slot skipped", int'(lk_hit), 1);

    tag = "R6";
    cmd(0, 0, 0);
    probe('h100);
    look('h202, 2); chk("R6 unlocked flushed", int'(lk_hit), 0);
    look('h102, 5); chk("R6 locked survives", int'(lk_hit), 1);

    tag = "R12";
    cmd_valid = 1; cmd_op = 3'd3; cmd_vpn = 20'h102; lk_vpn = 20'h102; lk_asid = 8'd4;
    #1; chk("R12 same-cycle old state", int'(lk_hit), 1);
    step(); cmd_valid = 0;
    look('h102, 4); chk("R9 page-any removes locked global", int'(lk_hit), 0);

    tag = "R8";
    for (int i = 0; i < 4; i++) fill('h300 + i, 'h7000 + i, 5, 0);
    fill('h304, 'h7004, 5, 1);
    fill('h305, 'h7005, 6, 1);
    cmd(2, 0, 5);
    look('h301, 5); chk("R8 tag removes", int'(lk_hit), 0);
    look('h304, 5); chk("R8 global kept", int'(lk_hit), 1);

    tag = "R7";
    cmd(1, 'h305, 7);
    look('h305, 6); chk("R7 global page match", int'(lk_hit), 0);
    cmd(1, 'h103, 2);
    look('h103, 1); chk("R7 tag mismatch kept", int'(lk_hit), 1);
    cmd(1, 'h103, 1);
    look('h103, 1); chk("R7 page+tag removes", int'(lk_hit), 0);

    tag = "R10";
    fill('h400, 'h8000, 3, 0);
    lock('h400, 3);
    lock('h304, 1);
    cmd(4, 0, 0);
    look('h400, 3); chk("R10 unlock keeps valid", int'(lk_hit), 1);
    cmd(0, 0, 0);
    look('h400, 3); chk("R10 unlocked then flushed", int'(lk_hit), 0);

    tag = "R12";
    fill('h500, 'h9000, 1, 0);
    cmd(5, 'h500, 1); cmd(6, 'h500, 1); cmd(7, 'h500, 1);
    look('h500, 1); chk("R12 unused opcode no effect", int'(lk_hit), 1);

    tag = "R5";
    fill_valid = 1; fill_vpn = 20'h501; fill_ppn = 20'h9001; fill_asid = 8'd1; fill_global = 0;
    cmd_valid = 1; cmd_op = 3'd5;
    step();
    cmd_valid = 0;
    look('h501, 1); chk("R5 held fill taken", int'(lk_hit), 1);
    fill_valid = 0;

    tag = "R4";
    cmd(3, 'h500, 0); cmd(3, 'h501, 0);
    for (int i = 0; i < N; i++) fill('h600 + i, 'hA000 + i, 2, 0);
    for (int i = 0; i < N; i++) lock('h600 + i, 2);
    lk_vpn = 20'h700; lk_asid = 8'd2;
    fill('h700, 'hB000, 2, 0);
    chk("R4 error pulse", int'(fill_err), 1);
    look('h700, 2); chk("R4 pulse ends", int'(fill_err), 0);
    chk("R4 fill dropped", int'(lk_hit), 0);
    probe('h600);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule